// File: doc/BRIEF.md
# JTAG Flash Buffer Programmer

This controller lets an external tester program a parallel NOR flash through the test access port, one whole program buffer per data-register scan. The tester selects a private instruction and shifts one 256-bit scan of sixteen 16-bit words. At Update-DR the scan is copied into a shadow slot. A word sequencer then replays the complete buffer-program command on the flash pins: the command word, the word count, the sixteen data words and the confirm word. The next scan can shift in while the current buffer is still being written or burned.

A second private instruction reaches a 23-bit base-address register. The address generator drives the base for the command words and base plus offset for the data words. The base moves forward by one buffer after each completed program operation. After the confirm word the controller waits for the flash ready line. One further buffer can wait in the shadow slot. An update that finds the slot occupied is dropped and raises a sticky overflow flag. Every capture of the buffer register reports the busy and overflow flags and the flash data bus. All logic runs on TCK.

Top module: `jtag_flash_bufprog`

## Requirements
- R1: The instruction register is 4 bits wide. Capture-IR loads 4'b0001, and Test-Logic-Reset selects BYPASS. Code 0x8 selects the 256-bit buffer register and 0x9 the 23-bit address register. Every other code selects a 1-bit bypass register that captures 0. All registers shift from TDI toward bit 0, and TDO shows bit 0 of the register being shifted.
- R2: While TRST_N is low and after it rises, CE#, WE# and OE# are high and no flash write occurs until a buffer is updated.
- R3: Each Update-DR of the buffer register (when the slot is free) produces exactly 19 flash writes in order. 0x00E8 goes to the base, then 0x000F to the base. Data word k, taken from scan bits [16k+15:16k] (bit 0 is shifted first), goes to base+k for k = 0..15. The last write is 0x00D0 to the base.
- R4: For every write, CE# is low in the cycle before, during and after the WE# pulse. WE# is low for exactly one TCK cycle. Address and data equal their values in the cycle before and in the cycle after the pulse.
- R5: OE# stays high at all times.
- R6: After a confirm word, no flash write occurs until the ready input has been observed high.
- R7: Update-DR of the address register loads the base. Capture-DR of it returns the current base. The base increases by 16 after each completed buffer.
- R8: A buffer updated while another is being written or burned is held and then written, at the next base, once the ready input is high.
- R9: Capture-DR of the buffer register loads bit 0 with busy (a buffer active or held), bit 1 with the overflow flag, bits [17:2] with the flash data bus input, and zeros in all other bits.
- R10: An update of the buffer register while a buffer is already held is discarded and sets the overflow flag. The flag stays set until the TAP passes through Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, the only clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdo | output | 1 | Test data out, bit 0 of the register being shifted |
| fl_rdy | input | 1 | Flash ready (high) / busy (low) |
| fl_dq_in | input | 16 | Flash data bus as read back |
| fl_addr | output | 23 | Flash word address |
| fl_dq_out | output | 16 | Flash write data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The bench runs a sweep of buffers with distinct word patterns. One data word equals the confirm code, so a sequencer that decoded values instead of positions would stop early. It checks all 19 writes of each buffer against arithmetic expectations, so a wrong word offset or a base that fails to advance shows up at once. It then pushes four back-to-back scans into a long burn, which must queue the second, drop the third and fourth, and report the overflow in the next capture. It also counts pulses seen while the flash is busy or without setup and hold, and checks that Test-Logic-Reset clears the flag. A design that overwrote the held buffer, started early, or kept the flag would show the wrong write log or the wrong captured status.

// File: rtl/jtag_flash_bufprog.sv
module jtag_flash_bufprog #(
  parameter int DW = 16,
  parameter int WORDS = 16,
  parameter int AW = 23,
  parameter logic [3:0] IR_BUF = 4'h8,
  parameter logic [3:0] IR_ADR = 4'h9,
  parameter logic [DW-1:0] CMD_LOAD = 'h00E8,
  parameter logic [DW-1:0] CMD_GO = 'h00D0
) (
  input  logic          tck,
  input  logic          tms,
  input  logic          tdi,
  input  logic          trst_n,
  output logic          tdo,
  input  logic          fl_rdy,
  input  logic [DW-1:0] fl_dq_in,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int BL  = DW * WORDS;
  localparam int NW  = WORDS + 3;
  localparam int IW  = $clog2(NW);
  localparam int WSW = $clog2(WORDS);
  localparam logic [3:0] IR_BYP = 4'hF;

  typedef enum logic [3:0] {
    T_TLR, T_IDLE, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
    T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
  } tap_t;

  typedef enum logic [2:0] {S_IDLE, S_SET, S_PUL, S_HLD, S_WAIT} seq_t;

  tap_t tap, tap_nx;
  logic [3:0] ir, ir_sh;
  logic [BL-1:0] sh_buf, que, act;
  logic [AW-1:0] sh_adr, base, act_base;
  logic byp, que_v, ovf;
  seq_t seq;
  logic [IW-1:0] idx;

  always_comb begin
    case (tap)
      T_TLR:  tap_nx = tms ? T_TLR  : T_IDLE;
      T_IDLE: tap_nx = tms ? T_SDR  : T_IDLE;
      T_SDR:  tap_nx = tms ? T_SIR  : T_CDR;
      T_CDR:  tap_nx = tms ? T_E1DR : T_SHDR;
      T_SHDR: tap_nx = tms ? T_E1DR : T_SHDR;
      T_E1DR: tap_nx = tms ? T_UDR  : T_PDR;
      T_PDR:  tap_nx = tms ? T_E2DR : T_PDR;
      T_E2DR: tap_nx = tms ? T_UDR  : T_SHDR;
      T_UDR:  tap_nx = tms ? T_SDR  : T_IDLE;
      T_SIR:  tap_nx = tms ? T_TLR  : T_CIR;
      T_CIR:  tap_nx = tms ? T_E1IR : T_SHIR;
      T_SHIR: tap_nx = tms ? T_E1IR : T_SHIR;
      T_E1IR: tap_nx = tms ? T_UIR  : T_PIR;
      T_PIR:  tap_nx = tms ? T_E2IR : T_PIR;
      T_E2IR: tap_nx = tms ? T_UIR  : T_SHIR;
      T_UIR:  tap_nx = tms ? T_SDR  : T_IDLE;
      default: tap_nx = T_TLR;
    endcase
  end

  wire sel_buf = (ir == IR_BUF);
  wire sel_adr = (ir == IR_ADR);
  wire busy    = (seq != S_IDLE) || que_v;
  wire upd_buf = (tap == T_UDR) && sel_buf;
  wire upd_adr = (tap == T_UDR) && sel_adr;
  wire take    = (seq == S_IDLE) && que_v;
  wire last_wd = (idx == IW'(NW - 1));

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tap    <= T_TLR;
      ir     <= IR_BYP;
      ir_sh  <= '0;
      sh_buf <= '0;
      sh_adr <= '0;
      byp    <= 1'b0;
    end else begin
      tap <= tap_nx;
      case (tap)
        T_TLR:  ir <= IR_BYP;
        T_CIR:  ir_sh <= 4'b0001;
        T_SHIR: ir_sh <= {tdi, ir_sh[3:1]};
        T_UIR:  ir <= ir_sh;
        T_CDR: begin
          if (sel_buf)      sh_buf <= BL'({fl_dq_in, ovf, busy});
          else if (sel_adr) sh_adr <= base;
          else              byp <= 1'b0;
        end
        T_SHDR: begin
          if (sel_buf)      sh_buf <= {tdi, sh_buf[BL-1:1]};
          else if (sel_adr) sh_adr <= {tdi, sh_adr[AW-1:1]};
          else              byp <= tdi;
        end
        default: ;
      endcase
    end
  end

  assign tdo = (tap == T_SHIR) ? ir_sh[0] :
               sel_buf ? sh_buf[0] :
               sel_adr ? sh_adr[0] : byp;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      que      <= '0;
      que_v    <= 1'b0;
      ovf      <= 1'b0;
      act      <= '0;
      act_base <= '0;
      base     <= '0;
      seq      <= S_IDLE;
      idx      <= '0;
    end else begin
      if (tap == T_TLR) ovf <= 1'b0;
      if (upd_buf) begin
        if (que_v && !take) ovf <= 1'b1;
        else begin
          que   <= sh_buf;
          que_v <= 1'b1;
        end
      end else if (take) begin
        que_v <= 1'b0;
      end

      case (seq)
        S_IDLE: if (que_v) begin
          act      <= que;
          act_base <= base;
          idx      <= '0;
          seq      <= S_SET;
        end
        S_SET: seq <= S_PUL;
        S_PUL: seq <= S_HLD;
        S_HLD: begin
          if (last_wd) seq <= S_WAIT;
          else begin
            idx <= idx + 1'b1;
            seq <= S_SET;
          end
        end
        S_WAIT: if (fl_rdy) seq <= S_IDLE;
        default: seq <= S_IDLE;
      endcase

      if (upd_adr) base <= sh_adr;
      else if (seq == S_WAIT && fl_rdy) base <= base + AW'(WORDS);
    end
  end

  wire in_word = (seq == S_SET) || (seq == S_PUL) || (seq == S_HLD);
  wire is_data = (idx >= IW'(2)) && (idx < IW'(WORDS + 2));
  wire [WSW-1:0] wsel = is_data ? WSW'(idx - IW'(2)) : '0;

  assign fl_ce_n   = !in_word;
  assign fl_we_n   = (seq != S_PUL);
  assign fl_oe_n   = 1'b1;
  assign fl_addr   = is_data ? act_base + AW'(wsel) : act_base;
  assign fl_dq_out = !in_word          ? '0 :
                     (idx == '0)       ? CMD_LOAD :
                     (idx == IW'(1))   ? DW'(WORDS - 1) :
                     is_data           ? act[wsel*DW +: DW] : CMD_GO;

  // R4
  we_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !fl_we_n |=> fl_we_n);
  // R4
  we_ce_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !fl_we_n |-> !fl_ce_n);
  // R4
  setup_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out) && $stable(fl_ce_n)));
  // R4
  hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out) && !fl_ce_n));
  // R6
  rdy_wait_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (seq == S_WAIT && !fl_rdy) |=> (seq == S_WAIT && fl_we_n));
  // R8
  que_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (que_v && seq != S_IDLE) |=> que_v);
  // R10
  ovf_sticky_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ovf && tap != T_TLR) |=> ovf);
endmodule

// File: tb/jtag_flash_bufprog_tb.sv
module jtag_flash_bufprog_tb;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
  logic fl_rdy = 1'b1;
  logic [15:0] fl_dq_in = '0;
  logic tdo, fl_ce_n, fl_we_n, fl_oe_n;
  logic [22:0] fl_addr;
  logic [15:0] fl_dq_out;

  jtag_flash_bufprog u_dut (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
    .fl_rdy(fl_rdy), .fl_dq_in(fl_dq_in), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n)
  );

  always #10 tck = ~tck;

  int tests = 0, fails = 0;
  int nlog = 0, busy_cnt = 0, busy_len = 20;
  int busy_viol = 0, tim_viol = 0, oe_bad = 0;
  logic [22:0] log_a [0:159];
  logic [15:0] log_d [0:159];
  logic p_we = 1'b1, p_ce = 1'b1;
  logic [22:0] p_a = '0;
  logic [15:0] p_d = '0;

  always @(negedge tck) begin
    if (trst_n) begin
      if (!fl_oe_n) oe_bad++;
      if (!fl_we_n) begin
        if (!p_we || p_ce || fl_ce_n || p_a != fl_addr || p_d != fl_dq_out) tim_viol++;
        if (busy_cnt != 0) busy_viol++;
        if (nlog < 160) begin
          log_a[nlog] = fl_addr;
          log_d[nlog] = fl_dq_out;
        end
        nlog++;
        if (nlog % 19 == 0) busy_cnt = busy_len;
      end else begin
        if (!p_we && (fl_ce_n || p_a != fl_addr || p_d != fl_dq_out)) tim_viol++;
        if (busy_cnt > 0) busy_cnt--;
      end
    end
    fl_rdy = (busy_cnt == 0);
    p_we = fl_we_n; p_ce = fl_ce_n; p_a = fl_addr; p_d = fl_dq_out;
  end

  task automatic chk(input string tag, input logic [63:0] actv, input logic [63:0] expv);
    tests++;
    if (actv !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(negedge tck);
  endtask

  task automatic tap_reset();
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      step(i == 3, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [255:0] din, output logic [255:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [15:0] pat(input int b, input int k);
    if (k == 5) return 16'h00D0;
    return 16'(b * 16'h1357 + k * 16'h0111 + 1);
  endfunction

  function automatic logic [255:0] bufvec(input int b);
    logic [255:0] v;
    for (int k = 0; k < 16; k++) v[16*k +: 16] = pat(b, k);
    return v;
  endfunction

  task automatic wait_log(input int target);
    for (int i = 0; i < 20000 && !(nlog >= target && busy_cnt == 0); i++) @(negedge tck);
    repeat (4) @(negedge tck);
  endtask

  task automatic check_buffer(input int s, input logic [22:0] bse, input int b);
    chk("R3 cmd", {log_a[s], log_d[s]}, {bse, 16'h00E8});
    chk("R3 count", {log_a[s+1], log_d[s+1]}, {bse, 16'h000F});
    for (int k = 0; k < 16; k++)
      chk("R3 data", {log_a[s+2+k], log_d[s+2+k]}, {23'(bse + 23'(k)), pat(b, k)});
    chk("R3 confirm", {log_a[s+18], log_d[s+18]}, {bse, 16'h00D0});
  endtask

  localparam logic [22:0] BASE0 = 23'h012340;

  initial begin
    repeat (100000) @(posedge tck);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [3:0] cap;
    logic [255:0] dout;
    int s;
    repeat (4) @(negedge tck);
    // R2 reset state
    chk("R2 reset pins", {61'b0, fl_ce_n, fl_we_n, fl_oe_n}, 64'h7);
    trst_n = 1'b1;
    tap_reset();
    repeat (20) @(negedge tck);
    chk("R2 no write", 64'(nlog), 64'd0);
    chk("R2 idle pins", {62'b0, fl_ce_n, fl_we_n}, 64'h3);

    // R1 IR capture and bypass paths
    shift_ir(4'hF, cap);
    chk("R1 ir capture", 64'(cap), 64'h1);
    scan_dr(8, 256'hA5, dout);
    chk("R1 bypass", 64'(dout[7:0]), 64'({8'hA5} << 1) & 64'hFF);
    shift_ir(4'h3, cap);
    scan_dr(8, 256'h3C, dout);
    chk("R1 unknown code bypass", 64'(dout[7:0]), 64'h78);

    // R7 base load and capture
    shift_ir(4'h9, cap);
    scan_dr(23, 256'(BASE0), dout);
    chk("R7 base reset capture", 64'(dout[22:0]), 64'h0);
    scan_dr(23, 256'(BASE0), dout);
    chk("R7 base readback", 64'(dout[22:0]), 64'(BASE0));

    // R3 R9 sweep of buffers
    shift_ir(4'h8, cap);
    busy_len = 30;
    for (int b = 0; b < 4; b++) begin
      fl_dq_in = (b == 0) ? 16'hC3A5 : pat(9, b);
      s = nlog;
      scan_dr(256, bufvec(b), dout);
      chk("R9 capture low", 64'(dout[17:0]), 64'({fl_dq_in, 2'b00}));
      chk("R9 capture zeros", 64'(|dout[255:18]), 64'h0);
      wait_log(s + 19);
      chk("R3 write count", 64'(nlog), 64'(s + 19));
      check_buffer(s, 23'(BASE0 + 23'(16 * b)), b);
    end

    // R8 R10 queue and overflow under a long burn
    busy_len = 1500;
    fl_dq_in = 16'h0000;
    s = nlog;
    scan_dr(256, bufvec(4), dout);
    chk("R9 idle status", 64'(dout[1:0]), 64'h0);
    scan_dr(256, bufvec(5), dout);
    chk("R9 busy status", 64'(dout[1:0]), 64'h1);
    scan_dr(256, bufvec(6), dout);
    chk("R10 no overflow yet", 64'(dout[1:0]), 64'h1);
    scan_dr(256, bufvec(7), dout);
    chk("R10 overflow flagged", 64'(dout[1:0]), 64'h3);
    wait_log(s + 38);
    repeat (100) @(negedge tck);
    chk("R10 dropped buffers", 64'(nlog), 64'(s + 38));
    check_buffer(s, 23'(BASE0 + 23'd64), 4);
    check_buffer(s + 19, 23'(BASE0 + 23'd80), 5);
    chk("R8 queued started", 64'(log_d[s + 21]), 64'(pat(5, 0)));

    // R10 cleared by Test-Logic-Reset
    tap_reset();
    shift_ir(4'h8, cap);
    chk("R1 ir capture after reset", 64'(cap), 64'h1);
    busy_len = 10;
    s = nlog;
    scan_dr(256, bufvec(8), dout);
    chk("R10 overflow cleared", 64'(dout[1:0]), 64'h0);
    wait_log(s + 19);
    check_buffer(s, 23'(BASE0 + 23'd96), 8);

    // R7 base advanced by completed buffers
    shift_ir(4'h9, cap);
    scan_dr(23, 256'(BASE0), dout);
    chk("R7 base advanced", 64'(dout[22:0]), 64'(23'(BASE0 + 23'd112)));

    chk("R4 write timing", 64'(tim_viol), 64'd0);
    chk("R5 oe high", 64'(oe_bad), 64'd0);
    chk("R6 no write while busy", 64'(busy_viol), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule